// File: doc/BRIEF.md
# Fast link training sequencer

This block runs one open-loop training pass on a serial display link. It uses a single fixed drive setting, fixed settle waits and no adjustment loop. On a start pulse it captures the active lane count, the link rate code and the scramble enable. It then issues a fixed series of sink register writes and status reads through a simple request port, and drives a local pattern selector for the transmitter. The pass has three phases: clock recovery with pattern 1, channel equalization with pattern 3, and a re-check of every active lane after training is switched off.

Each status read is judged against a mask built from the lane count, so bits that belong to unused lanes have no effect. The first failed check ends the pass at once, and a code names the phase that failed. When the pass ends, the block raises `done`. It holds `done` and the result until the next start.

Top module: `fast_lt_seq`

## Requirements
- R1: After reset, `req_valid`, `done`, `link_ok`, `pat_sel` and `fail_code` are all 0.
- R2: A passing run accepts, in this order: a write of 0x01 to 0x108; a write of 0x21 to 0x102; a write of 0x24 to each address 0x103+k for lanes k=0..N-1; a read of 0x202; a write to 0x10A; a pattern write to 0x102; a second set of 0x24 lane writes; a read of 0x202; a write of 0x00 to 0x102; and then one final read per lane.
- R3: The status read of each phase is requested exactly WAIT_CYC+1 cycles after the last lane write of that phase is accepted, where WAIT_CYC = CLK_MHZ*WAIT_US.
- R4: Clock recovery passes when the 16-bit response has every bit of (mask AND 0x1111) set, with mask = 0xFFFF >> ((4-N)*4). Otherwise the run ends with `fail_code` 1, and bits outside the mask are ignored.
- R5: Equalization passes when (response AND mask) equals (0x7777 AND mask). Otherwise the run ends with `fail_code` 2, so a set bit 3 of an active lane's nibble also fails.
- R6: The equalization pattern write carries 0x23 when the captured rate code is 20 (0x14), and 0x22 otherwise.
- R7: The write to 0x10A carries the captured scramble enable in bit 0 and zeros in the other bits.
- R8: The final check reads byte 0x202 for lanes 0 and 1 and byte 0x203 for lanes 2 and 3, using response bits [7:0]. An even lane uses bits [2:0] and an odd lane uses bits [6:4], and all three bits must be set. The first lane that fails ends the run with `fail_code` 3.
- R9: `pat_sel` is 0 when idle, 1 (pattern 1) from the acceptance of the coding write until the write to 0x10A is accepted, 3 (pattern 3) from then until the clearing write to 0x102 is accepted, and 0 after that. It never takes the value 2.
- R10: A request holds `req_valid`, the address, the data and the direction until `req_ready`. At most one read is outstanding, and a read completes on `rsp_valid`.
- R11: `done` stays high with `fail_code` stable until the next start, and `link_ok` is `done` with code 0. A start during a run is ignored, and so are changes to the configuration inputs during a run.
- R12: After `done` rises, no request is issued until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training pass (sampled when idle or done) |
| lane_cnt | input | 3 | Active lanes, 1 to 4 |
| rate_code | input | 8 | Link rate code |
| scramble_en | input | 1 | Alternate scrambler reset enable |
| pat_sel | output | 2 | Local pattern: 0 off, 1 pattern 1, 3 pattern 3 |
| req_valid | output | 1 | Request valid |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | ADDR_W | Sink register address |
| req_wdata | output | 8 | Write data |
| req_ready | input | 1 | Request accepted this cycle |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data, byte at addr in [7:0], next byte in [15:8] |
| done | output | 1 | Pass finished |
| fail_code | output | 2 | 0 pass, 1 clock recovery, 2 equalization, 3 final check |
| link_ok | output | 1 | Finished with no failure |

## Verification
The checker assumes that `lane_cnt` lies between 1 and 4 when a pass starts. It also assumes that `rsp_valid` arrives only while a read is outstanding, and only after the cycle in which that read was accepted. The bench sink model meets these assumptions: it uses only legal lane counts, and it answers every accepted read with a single response pulse two cycles later. It also stalls `req_ready` on alternate cycles in one scenario, which tests the hold rule.

// File: rtl/fast_lt_seq.sv
module fast_lt_seq #(
  parameter int CLK_MHZ = 100,
  parameter int WAIT_US = 520,
  parameter int ADDR_W  = 20,
  parameter logic [7:0] RATE_HI = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        lane_cnt,
  input  logic [7:0]        rate_code,
  input  logic              scramble_en,
  output logic [1:0]        pat_sel,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  output logic              done,
  output logic [1:0]        fail_code,
  output logic              link_ok
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [1:0] FC_OK = 2'd0, FC_CR = 2'd1, FC_EQ = 2'd2, FC_FIN = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CODE, ST_TP1, ST_LS1, ST_WT1, ST_RD1, ST_ASSR,
    ST_TP3, ST_LS2, ST_WT2, ST_RD2, ST_OFF, ST_FIN, ST_DONE
  } st_t;

  st_t             st;
  logic [2:0]      n_q, ln;
  logic            hi_q, scr_q, rd_pend;
  logic [CNT_W-1:0] cnt;
  logic [1:0]      code_q;

  logic [4:0]  sh;
  logic [15:0] mask, cr_need;
  logic [2:0]  fin_nib;
  logic        cr_ok, eq_ok, fin_ok, is_rd, is_op, acc, got, last_ln;

  assign sh      = {3'd4 - n_q, 2'b00};
  assign mask    = 16'hFFFF >> sh;
  assign cr_need = mask & 16'h1111;
  assign cr_ok   = (rsp_data & cr_need) == cr_need;
  assign eq_ok   = (rsp_data & mask) == (16'h7777 & mask);
  assign fin_nib = ln[0] ? rsp_data[6:4] : rsp_data[2:0];
  assign fin_ok  = &fin_nib;
  assign last_ln = ln == n_q - 3'd1;

  assign is_rd = st == ST_RD1 || st == ST_RD2 || st == ST_FIN;
  assign is_op = is_rd || st == ST_CODE || st == ST_TP1 || st == ST_LS1 ||
                 st == ST_ASSR || st == ST_TP3 || st == ST_LS2 || st == ST_OFF;
  assign req_valid = is_op && !rd_pend;
  assign req_write = !is_rd;
  assign acc = req_valid && req_ready;
  assign got = rd_pend && rsp_valid;

  always_comb begin
    req_addr  = '0;
    req_wdata = 8'h00;
    case (st)
      ST_CODE: begin req_addr = ADDR_W'(12'h108); req_wdata = 8'h01; end
      ST_TP1:  begin req_addr = ADDR_W'(12'h102); req_wdata = 8'h21; end
      ST_LS1, ST_LS2: begin req_addr = ADDR_W'(12'h103 + {9'd0, ln}); req_wdata = 8'h24; end
      ST_RD1, ST_RD2: req_addr = ADDR_W'(12'h202);
      ST_ASSR: begin req_addr = ADDR_W'(12'h10A); req_wdata = {7'd0, scr_q}; end
      ST_TP3:  begin req_addr = ADDR_W'(12'h102); req_wdata = hi_q ? 8'h23 : 8'h22; end
      ST_OFF:  req_addr = ADDR_W'(12'h102);
      ST_FIN:  req_addr = ADDR_W'(12'h202 + {11'd0, ln[1]});
      default: ;
    endcase
  end

  always_comb begin
    case (st)
      ST_TP1, ST_LS1, ST_WT1, ST_RD1, ST_ASSR: pat_sel = 2'd1;
      ST_TP3, ST_LS2, ST_WT2, ST_RD2, ST_OFF:  pat_sel = 2'd3;
      default: pat_sel = 2'd0;
    endcase
  end

  assign done      = st == ST_DONE;
  assign fail_code = code_q;
  assign link_ok   = done && code_q == FC_OK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      n_q     <= 3'd1;
      ln      <= '0;
      hi_q    <= 1'b0;
      scr_q   <= 1'b0;
      rd_pend <= 1'b0;
      cnt     <= '0;
      code_q  <= FC_OK;
    end else begin
      if (is_rd && acc) rd_pend <= 1'b1;
      if (got) rd_pend <= 1'b0;
      case (st)
        ST_IDLE, ST_DONE:
          if (start) begin
            n_q    <= lane_cnt;
            hi_q   <= rate_code == RATE_HI;
            scr_q  <= scramble_en;
            code_q <= FC_OK;
            st     <= ST_CODE;
          end
        ST_CODE: if (acc) st <= ST_TP1;
        ST_TP1:  if (acc) begin ln <= '0; st <= ST_LS1; end
        ST_LS1, ST_LS2:
          if (acc) begin
            if (last_ln) begin
              cnt <= '0;
              st  <= (st == ST_LS1) ? ST_WT1 : ST_WT2;
            end else ln <= ln + 3'd1;
          end
        ST_WT1, ST_WT2: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(WAIT_CYC - 1)) st <= (st == ST_WT1) ? ST_RD1 : ST_RD2;
        end
        ST_RD1:
          if (got) begin
            if (cr_ok) st <= ST_ASSR;
            else begin code_q <= FC_CR; st <= ST_DONE; end
          end
        ST_ASSR: if (acc) st <= ST_TP3;
        ST_TP3:  if (acc) begin ln <= '0; st <= ST_LS2; end
        ST_RD2:
          if (got) begin
            if (eq_ok) st <= ST_OFF;
            else begin code_q <= FC_EQ; st <= ST_DONE; end
          end
        ST_OFF:  if (acc) begin ln <= '0; st <= ST_FIN; end
        ST_FIN:
          if (got) begin
            if (!fin_ok) begin code_q <= FC_FIN; st <= ST_DONE; end
            else if (last_ln) st <= ST_DONE;
            else ln <= ln + 3'd1;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fast_lt_seq_chk.sv
module fast_lt_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        pat_sel,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              done,
  input logic [1:0]        fail_code
);
  logic pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (req_valid && req_ready && !req_write) pend <= 1'b1;
    else if (rsp_valid) pend <= 1'b0;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
    $stable(req_wdata) && $stable(req_write));

  // R10
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !req_valid);

  // R9
  pat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_sel != 2'd2);

  // R9
  pat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_sel == 2'd3 |-> $past(pat_sel) != 2'd0);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(fail_code));

  // R12
  quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

bind fast_lt_seq fast_lt_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fast_lt_seq_tb.sv
module fast_lt_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 1;
  localparam int WUS = 520;
  localparam int WCYC = MHZ * WUS;

  logic clk, rst_n, start, scramble_en, req_valid, req_write, req_ready, rsp_valid;
  logic done, link_ok;
  logic [2:0] lane_cnt;
  logic [7:0] rate_code, req_wdata;
  logic [1:0] pat_sel, fail_code;
  logic [19:0] req_addr;
  logic [15:0] rsp_data;

  fast_lt_seq #(.CLK_MHZ(MHZ), .WAIT_US(WUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
    .rate_code(rate_code), .scramble_en(scramble_en), .pat_sel(pat_sel),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done), .fail_code(fail_code), .link_ok(link_ok));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int lnum = 0, rdn = 0, enm = 0;
  bit stall_en = 0;
  int lc[64];
  bit lw[64], ew[64];
  logic [19:0] la[64], ea[64];
  logic [7:0] ld[64], ed[64];
  logic [1:0] lp[64], ep[64];
  logic [15:0] st_cr, st_eq, st_fin;

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // AUX sink model: records accepted requests, answers reads two cycles later
  initial begin
    int rcnt;
    logic [15:0] pend;
    rcnt = 0; pend = '0;
    req_ready = 1; rsp_valid = 0; rsp_data = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin rsp_valid = 1; rsp_data = pend; end
      end
      req_ready = stall_en ? cyc[0] : 1'b1;
      if (req_valid && req_ready && lnum < 64) begin
        lc[lnum] = cyc; lw[lnum] = req_write; la[lnum] = req_addr;
        ld[lnum] = req_wdata; lp[lnum] = pat_sel; lnum++;
        if (!req_write) begin
          if (rdn == 0) pend = st_cr;
          else if (rdn == 1) pend = st_eq;
          else pend = (req_addr == 20'h202) ? st_fin : {8'h00, st_fin[15:8]};
          rdn++;
          rcnt = 2;
        end
      end
      cyc++;
    end
  end

  task automatic push(bit w, int a, int d, int p);
    ew[enm] = w; ea[enm] = 20'(a); ed[enm] = 8'(d); ep[enm] = 2'(p); enm++;
  endtask

  task automatic build(int n, int rate, int scr, int stage, int nfin);
    enm = 0;
    push(1, 'h108, 'h01, 0);
    push(1, 'h102, 'h21, 1);
    for (int j = 0; j < n; j++) push(1, 'h103 + j, 'h24, 1);
    push(0, 'h202, 0, 1);
    if (stage == 1) return;
    push(1, 'h10A, scr, 1);
    push(1, 'h102, (rate == 20) ? 'h23 : 'h22, 3);
    for (int j = 0; j < n; j++) push(1, 'h103 + j, 'h24, 3);
    push(0, 'h202, 0, 3);
    if (stage == 2) return;
    push(1, 'h102, 'h00, 3);
    for (int k = 0; k < nfin; k++) push(0, 'h202 + k/2, 0, 0);
  endtask

  task automatic compare(string req);
    int bad;
    bad = 0;
    chk(lnum == enm, req, "request count", lnum, enm);
    for (int i = 0; i < enm && i < lnum; i++) begin
      if (lw[i] !== ew[i] || la[i] !== ea[i] || (lw[i] && ld[i] !== ed[i]) || lp[i] !== ep[i]) begin
        if (bad == 0)
          $display("FAIL %s entry %0d: actual w%0d a%0h d%0h p%0d expected w%0d a%0h d%0h p%0d",
                   req, i, lw[i], la[i], ld[i], lp[i], ew[i], ea[i], ed[i], ep[i]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  task automatic kick(int n, int rate, int scr);
    @(negedge clk);
    lnum = 0; rdn = 0;
    lane_cnt = 3'(n); rate_code = 8'(rate); scramble_en = 1'(scr);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(string req);
    int t;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, req, "done reached", done, 1);
  endtask

  task automatic t_reset();
    rst_n = 0; start = 0; lane_cnt = 1; rate_code = 0; scramble_en = 0;
    repeat (3) @(negedge clk);
    chk(req_valid == 0 && done == 0 && pat_sel == 0 && fail_code == 0 && link_ok == 0,
        "R1", "outputs in reset", {req_valid, done, pat_sel, fail_code, link_ok}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(req_valid == 0 && done == 0 && pat_sel == 0, "R1", "idle after reset",
        {req_valid, done, pat_sel}, 0);
  endtask

  task automatic t_pass4();
    st_cr = 16'h1111; st_eq = 16'h7777; st_fin = 16'h7777;
    kick(4, 10, 1);
    wait_done("R11");
    build(4, 10, 1, 3, 4);
    compare("R2");
    chk(lc[6] - lc[5] == WCYC + 1, "R3", "clock recovery wait", lc[6] - lc[5], WCYC + 1);
    chk(lc[13] - lc[12] == WCYC + 1, "R3", "equalization wait", lc[13] - lc[12], WCYC + 1);
    chk(fail_code == 0 && link_ok, "R11", "pass result", {fail_code, link_ok}, 1);
    chk(pat_sel == 0, "R9", "pattern off at end", pat_sel, 0);
    repeat (20) @(negedge clk);
    chk(lnum == enm && done && fail_code == 0, "R12", "quiet after done", lnum, enm);
  endtask

  task automatic t_pass1_masked();
    st_cr = 16'hEEE1; st_eq = 16'h8887; st_fin = 16'h00F7;
    kick(1, 20, 0);
    wait_done("R4");
    build(1, 20, 0, 3, 1);
    compare("R6");
    chk(link_ok, "R4", "bits outside mask ignored", fail_code, 0);
    chk(ld[4] == 8'h00, "R7", "scramble bit clear", ld[4], 0);
    chk(ld[5] == 8'h23, "R6", "rate 20 pattern code", ld[5], 'h23);
  endtask

  task automatic t_pass2_stall();
    st_cr = 16'h0011; st_eq = 16'h0077; st_fin = 16'h0077;
    stall_en = 1;
    kick(2, 10, 1);
    wait_done("R10");
    stall_en = 0;
    build(2, 10, 1, 3, 2);
    compare("R10");
    chk(link_ok, "R10", "pass under stalls", fail_code, 0);
    chk(ld[5] == 8'h01, "R7", "scramble bit set", ld[5], 1);
  endtask

  task automatic t_cr_fail();
    st_cr = 16'h1101; st_eq = 16'h7777; st_fin = 16'h7777;
    kick(2, 10, 0);
    wait_done("R4");
    chk(fail_code == 1 && !link_ok, "R4", "clock recovery failure code", fail_code, 1);
    repeat (20) @(negedge clk);
    build(2, 10, 0, 1, 0);
    compare("R12");
  endtask

  task automatic t_eq_fail();
    st_cr = 16'h1111; st_eq = 16'h7F77; st_fin = 16'h7777;
    kick(4, 20, 1);
    wait_done("R5");
    chk(fail_code == 2, "R5", "equalization failure code", fail_code, 2);
    repeat (20) @(negedge clk);
    build(4, 20, 1, 2, 0);
    compare("R5");
  endtask

  task automatic t_fin_fail4();
    st_cr = 16'h1111; st_eq = 16'h7777; st_fin = 16'h7377;
    kick(4, 10, 0);
    wait_done("R8");
    chk(fail_code == 3, "R8", "lane 2 final failure code", fail_code, 3);
    repeat (10) @(negedge clk);
    build(4, 10, 0, 3, 3);
    compare("R8");
  endtask

  task automatic t_fin_fail2();
    st_cr = 16'h0011; st_eq = 16'h0077; st_fin = 16'h0037;
    kick(2, 10, 0);
    wait_done("R8");
    chk(fail_code == 3, "R8", "lane 1 odd nibble failure", fail_code, 3);
    build(2, 10, 0, 3, 2);
    compare("R8");
  endtask

  task automatic t_busy_start();
    st_cr = 16'h1111; st_eq = 16'h7777; st_fin = 16'h7777;
    kick(4, 10, 0);
    repeat (50) @(negedge clk);
    lane_cnt = 1; rate_code = 20; scramble_en = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done("R11");
    build(4, 10, 0, 3, 4);
    compare("R11");
    chk(link_ok, "R11", "pass despite mid-run start", fail_code, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pass4();
    t_pass1_masked();
    t_pass2_stall();
    t_cr_fail();
    t_eq_fail();
    t_fin_fail4();
    t_fin_fail2();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule